// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block sits beside a single-core load/store unit and decides whether each store-exclusive may write to memory. Each request carries an operation, a base address, an immediate offset and an access size. The block adds base and offset to form the effective address. A load-exclusive opens a reservation that holds that address and the access size. A later store-exclusive is granted only if the reservation is still live and matches in both address and size.

The block never touches memory. One cycle after a request it raises a write enable when the store may proceed, and for a store-exclusive it also returns a status bit: 0 for success, 1 for failure. A snoop input reports writes made by other bus masters. A snooped write anywhere inside the aligned granule that holds the reserved address destroys the reservation. The block holds one reservation for one local processor.

Top module: `excl_monitor`

## Requirements
- R1: After reset no reservation exists and rsp_valid, rsp_status and wr_en are low. A store-exclusive issued before any load-exclusive fails.
- R2: Operation encoding on req_op is 0 = ordinary store, 1 = load-exclusive, 2 = store-exclusive, 3 = clear. Size encoding on req_size is 0 = byte, 1 = halfword, 2 = word. A load-exclusive records the effective address and the size.
- R3: A store-exclusive succeeds when all of these hold: a reservation is live, the effective address equals the reserved address, and the size equals the reserved size. On success, in the cycle after the request, rsp_valid = 1, rsp_status = 0 and wr_en = 1.
- R4: A store-exclusive whose effective address differs from the reserved address fails: rsp_valid = 1, rsp_status = 1, wr_en = 0.
- R5: A store-exclusive whose size differs from the reserved size fails, even when the address matches.
- R6: Every store-exclusive drops the reservation, whether it succeeds or fails, so a second store-exclusive with no new load-exclusive fails.
- R7: A clear request (op 3) drops the reservation.
- R8: A snooped write whose address lies in the same aligned GRANULE_BYTES granule as the reserved address drops the reservation. A snooped write outside that granule has no effect.
- R9: A new load-exclusive replaces any existing reservation with its own address and size.
- R10: The effective address is base plus the zero-extended offset, taken modulo 2^ADDR_W.
- R11: An ordinary store raises wr_en in the next cycle, keeps rsp_valid low, and leaves the reservation unchanged.
- R12: A snoop hit in the same cycle as a store-exclusive makes that store fail. A snoop to the granule of a load-exclusive in the same cycle leaves no reservation.
- R13: In a cycle after which no request was accepted, rsp_valid and wr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (R2) |
| req_base | input | ADDR_W | Base address |
| req_offset | input | OFS_W | Immediate offset, zero when unused |
| req_size | input | 2 | Access size code (R2) |
| snoop_valid | input | 1 | Another master writes this cycle |
| snoop_addr | input | ADDR_W | Address of that write |
| rsp_valid | output | 1 | Store-exclusive result present |
| rsp_status | output | 1 | 0 = success, 1 = failure |
| wr_en | output | 1 | Memory write allowed |

## Verification
The bench builds the block with ADDR_W = 16, OFS_W = 6 and GRANULE_BYTES = 4. The narrow address makes base-plus-offset wraparound easy to reach with small constants. The four-byte granule lets one snoop land at a byte offset inside the reserved word while another lands just past it, which separates a hit from a near miss. The bench also drives snoops in the same cycle as store-exclusive and load-exclusive requests, so the two same-cycle ordering rules are both exercised.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_LDX   = 2'd1,
    OP_STX   = 2'd2,
    OP_CLR   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;
endpackage

// File: rtl/excl_ea_gen.sv
module excl_ea_gen #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 12
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  offset,
  output logic [ADDR_W-1:0] ea
);
  function automatic logic [ADDR_W-1:0] calc_ea(input logic [ADDR_W-1:0] b,
                                                input logic [OFS_W-1:0] o);
    return b + ADDR_W'(o);
  endfunction

  assign ea = calc_ea(base, offset);
endmodule

// File: rtl/excl_resv_track.sv
module excl_resv_track #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_resv,
  input  logic              drop_resv,
  input  logic [ADDR_W-1:0] ea,
  input  logic [1:0]        size,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              resv_valid,
  output logic [ADDR_W-1:0] resv_addr,
  output logic [1:0]        resv_size,
  output logic              snoop_hit_cur
);
  function automatic logic same_granule(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] b);
    return a[ADDR_W-1:GRAN_LSB] == b[ADDR_W-1:GRAN_LSB];
  endfunction

  logic              nxt_valid;
  logic [ADDR_W-1:0] nxt_addr;
  logic [1:0]        nxt_size;
  logic              snoop_hit_nxt;

  always_comb begin
    nxt_valid = resv_valid;
    nxt_addr  = resv_addr;
    nxt_size  = resv_size;
    if (set_resv) begin
      nxt_valid = 1'b1;
      nxt_addr  = ea;
      nxt_size  = size;
    end else if (drop_resv) begin
      nxt_valid = 1'b0;
    end
  end

  assign snoop_hit_cur = snoop_valid && resv_valid && same_granule(snoop_addr, resv_addr);
  assign snoop_hit_nxt = snoop_valid && same_granule(snoop_addr, nxt_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_addr  <= '0;
      resv_size  <= '0;
    end else begin
      resv_valid <= nxt_valid && !snoop_hit_nxt;
      resv_addr  <= nxt_addr;
      resv_size  <= nxt_size;
    end
  end
endmodule

// File: rtl/excl_verdict.sv
module excl_verdict #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_stx,
  input  logic              is_store,
  input  logic              resv_valid,
  input  logic [ADDR_W-1:0] resv_addr,
  input  logic [1:0]        resv_size,
  input  logic [ADDR_W-1:0] ea,
  input  logic [1:0]        size,
  input  logic              snoop_hit_cur,
  output logic              stx_pass,
  output logic              rsp_valid,
  output logic              rsp_status,
  output logic              wr_en
);
  function automatic logic grant(input logic live, input logic addr_eq,
                                 input logic size_eq, input logic snooped);
    return live && addr_eq && size_eq && !snooped;
  endfunction

  assign stx_pass = grant(resv_valid, resv_addr == ea, resv_size == size, snoop_hit_cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= 1'b0;
      wr_en      <= 1'b0;
    end else begin
      rsp_valid  <= is_stx;
      rsp_status <= is_stx && !stx_pass;
      wr_en      <= is_store || (is_stx && stx_pass);
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int OFS_W         = 12,
  parameter int GRANULE_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              rsp_valid,
  output logic              rsp_status,
  output logic              wr_en
);
  localparam int GRAN_LSB = $clog2(GRANULE_BYTES);

  logic [ADDR_W-1:0] ea;
  logic              is_ldx, is_stx, is_clr, is_store;
  logic              resv_valid;
  logic [ADDR_W-1:0] resv_addr;
  logic [1:0]        resv_size;
  logic              snoop_hit_cur;
  logic              stx_pass;

  assign is_ldx   = req_valid && (op_e'(req_op) == OP_LDX);
  assign is_stx   = req_valid && (op_e'(req_op) == OP_STX);
  assign is_clr   = req_valid && (op_e'(req_op) == OP_CLR);
  assign is_store = req_valid && (op_e'(req_op) == OP_STORE);

  excl_ea_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ea (
    .base   (req_base),
    .offset (req_offset),
    .ea     (ea)
  );

  excl_resv_track #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_resv      (is_ldx),
    .drop_resv     (is_stx || is_clr),
    .ea            (ea),
    .size          (req_size),
    .snoop_valid   (snoop_valid),
    .snoop_addr    (snoop_addr),
    .resv_valid    (resv_valid),
    .resv_addr     (resv_addr),
    .resv_size     (resv_size),
    .snoop_hit_cur (snoop_hit_cur)
  );

  excl_verdict #(.ADDR_W(ADDR_W)) u_verdict (
    .clk           (clk),
    .rst_n         (rst_n),
    .is_stx        (is_stx),
    .is_store      (is_store),
    .resv_valid    (resv_valid),
    .resv_addr     (resv_addr),
    .resv_size     (resv_size),
    .ea            (ea),
    .size          (req_size),
    .snoop_hit_cur (snoop_hit_cur),
    .stx_pass      (stx_pass),
    .rsp_valid     (rsp_valid),
    .rsp_status    (rsp_status),
    .wr_en         (wr_en)
  );
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       rsp_valid,
  input logic       rsp_status,
  input logic       wr_en,
  input logic       resv_valid,
  input logic       snoop_hit_cur,
  input logic       stx_pass
);
  p_fail_blocks_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status) |-> !wr_en);

  p_result_next_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2) |=> rsp_valid);

  p_pass_gives_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2 && stx_pass) |=> (wr_en && !rsp_status));

  p_quiet_when_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !wr_en));

  p_stx_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2) |=> !resv_valid);

  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3) |=> !resv_valid);

  p_snoop_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit_cur && !(req_valid && req_op == 2'd1)) |=> !resv_valid);

  p_snoop_fails_stx_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2 && snoop_hit_cur) |=> rsp_status);

  p_store_no_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0) |=> (wr_en && !rsp_valid));
endmodule

bind excl_monitor excl_monitor_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_op        (req_op),
  .rsp_valid     (rsp_valid),
  .rsp_status    (rsp_status),
  .wr_en         (wr_en),
  .resv_valid    (resv_valid),
  .snoop_hit_cur (snoop_hit_cur),
  .stx_pass      (stx_pass)
);

// File: tb/excl_monitor_test.sv
`timescale 1ns/1ps
module excl_monitor_test;
  localparam int AW = 16;
  localparam int OW = 6;
  localparam int GB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_base = '0;
  logic [OW-1:0] req_offset = '0;
  logic [1:0]    req_size = 2'd0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          rsp_valid, rsp_status, wr_en;

  always #2.5 clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .OFS_W(OW), .GRANULE_BYTES(GB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_size(req_size),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .wr_en(wr_en)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  // reference state of the reservation
  bit          m_valid = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [1:0]  m_size = 2'd0;

  function automatic bit in_word(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (a / GB) == (b / GB);
  endfunction

  task automatic step(input bit v, input logic [1:0] op, input logic [AW-1:0] base,
                      input logic [OW-1:0] off, input logic [1:0] sz,
                      input bit sv, input logic [AW-1:0] sa, input string tag);
    logic [AW-1:0] addr;
    bit ok;
    bit e_v, e_s, e_w;
    bit n_v;
    logic [AW-1:0] n_a;
    logic [1:0] n_s;
    @(negedge clk);
    req_valid = v; req_op = op; req_base = base; req_offset = off; req_size = sz;
    snoop_valid = sv; snoop_addr = sa;
    addr = AW'((32'(base) + 32'(off)) % (32'd1 << AW));
    ok = m_valid && (m_addr == addr) && (m_size == sz) && !(sv && in_word(sa, m_addr));
    e_v = v && op == 2'd2;
    e_s = e_v && !ok;
    e_w = v && (op == 2'd0 || (op == 2'd2 && ok));
    n_v = m_valid; n_a = m_addr; n_s = m_size;
    if (v && op == 2'd1) begin n_v = 1; n_a = addr; n_s = sz; end
    else if (v && (op == 2'd2 || op == 2'd3)) n_v = 0;
    if (sv && in_word(sa, n_a)) n_v = 0;
    m_valid = n_v; m_addr = n_a; m_size = n_s;
    exp_q.push_back({e_v, e_s, e_w});
    tag_q.push_back(tag);
  endtask

  task automatic ldx(input logic [AW-1:0] a, input logic [1:0] sz, input string tag);
    step(1, 2'd1, a, '0, sz, 0, '0, tag);
  endtask
  task automatic stx(input logic [AW-1:0] a, input logic [1:0] sz, input string tag);
    step(1, 2'd2, a, '0, sz, 0, '0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 2'd0, '0, '0, 2'd0, 0, '0, tag);
  endtask

  // monitor: compares one expected item per clock
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if ({rsp_valid, rsp_status, wr_en} !== e) begin
        mismatched++;
        $display("FAIL %s: got v/s/we=%b expected %b", t, {rsp_valid, rsp_status, wr_en}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compared++;
    if ({rsp_valid, rsp_status, wr_en} !== 3'b000) begin
      mismatched++;
      $display("FAIL R1 reset: got %b expected 000", {rsp_valid, rsp_status, wr_en});
    end
    rst_n = 1'b1;
    stx(16'h0040, 2'd2, "R1 stx without reservation");
    // R2 / R3: load-exclusive via base+offset, matching store
    step(1, 2'd1, 16'h00F0, 6'h10, 2'd2, 0, '0, "R2 ldx base+offset");
    stx(16'h0100, 2'd2, "R3 matching stx");
    stx(16'h0100, 2'd2, "R6 second stx");
    ldx(16'h0200, 2'd1, "R4 ldx");
    stx(16'h0204, 2'd1, "R4 address mismatch");
    ldx(16'h0300, 2'd2, "R5 ldx");
    stx(16'h0300, 2'd0, "R5 size mismatch");
    ldx(16'h0400, 2'd2, "R7 ldx");
    step(1, 2'd3, '0, '0, 2'd0, 0, '0, "R7 clear");
    stx(16'h0400, 2'd2, "R7 stx after clear");
    ldx(16'h0500, 2'd2, "R8 ldx");
    step(0, 2'd0, '0, '0, 2'd0, 1, 16'h0503, "R8 snoop inside granule");
    stx(16'h0500, 2'd2, "R8 stx after snoop hit");
    ldx(16'h0600, 2'd2, "R8 ldx near miss");
    step(0, 2'd0, '0, '0, 2'd0, 1, 16'h0604, "R8 snoop next granule");
    stx(16'h0600, 2'd2, "R8 stx after near miss");
    ldx(16'h0700, 2'd2, "R9 first ldx");
    ldx(16'h0800, 2'd2, "R9 second ldx");
    stx(16'h0700, 2'd2, "R9 stx to replaced address");
    ldx(16'h0A00, 2'd0, "R9 ldx byte");
    ldx(16'h0B00, 2'd1, "R9 ldx half replaces");
    stx(16'h0B00, 2'd1, "R9 stx to newest");
    step(1, 2'd1, 16'hFFFE, 6'h04, 2'd2, 0, '0, "R10 ldx wrapping");
    stx(16'h0002, 2'd2, "R10 stx at wrapped address");
    ldx(16'h0C00, 2'd2, "R11 ldx");
    step(1, 2'd0, 16'h0C00, '0, 2'd2, 0, '0, "R11 ordinary store");
    stx(16'h0C00, 2'd2, "R11 stx after ordinary store");
    ldx(16'h0D00, 2'd2, "R12 ldx");
    step(1, 2'd2, 16'h0D00, '0, 2'd2, 1, 16'h0D02, "R12 stx with same-cycle snoop");
    step(1, 2'd1, 16'h0E00, '0, 2'd2, 1, 16'h0E01, "R12 ldx with same-cycle snoop");
    stx(16'h0E00, 2'd2, "R12 stx after snooped ldx");
    idle("R13 idle one");
    idle("R13 idle two");
    repeat (4) @(posedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule